// File: doc/BRIEF.md
# Prioritised Bus Interrupter with Identification Vector

This block is the requesting side of a prioritised interrupt scheme on an asynchronous backplane bus. Local logic pulses a request, and the block pulls low the one active-low request line that belongs to its configured priority level, from 1 to 7. Requests that arrive while one is already outstanding merge into it and are not queued. A configured level of 0 turns the block off.

An interrupt handler services the request by running an acknowledge cycle. It drives the acknowledge, address and data strobes low and puts the level it is serving on address bits 3..1. If that level equals the block's level and a request is outstanding, the block drives its configured 8-bit identification vector onto the data lines and pulls the data-acknowledge low. It holds both until the data strobe goes high, as it would in a normal read. If the level does not match, the block ignores the cycle.

A configuration bit picks one of two release policies. In the first, the request line drops when the acknowledge completes. In the second, the request line stays asserted until local logic clears it with a register-access pulse. The bus strobes are taken to be already synchronised to `clk`.

Top module: `irq_vector_src`

## Requirements
- R1: After reset, every bit of `irq_n` is 1, `dtack_n` is 1, `vec_oe` is 0 and `vec_out` is 0.
- R2: A `local_req` pulse sampled at a clock edge while `cfg_level` is L (1..7) makes `irq_n[L-1]` 0 after that edge. Every other bit of `irq_n` stays 1, so at most one bit of `irq_n` is ever 0.
- R3: While `cfg_level` is 0, every bit of `irq_n` is 1. A `local_req` in that state is ignored, and any outstanding request is discarded.
- R4: An acknowledge cycle hits the block when `iack_n`, `as_n` and `ds_n` are all 0, `addr_lvl` equals a nonzero `cfg_level`, and a request is outstanding. On the edge after a hit, `dtack_n` becomes 0, `vec_oe` becomes 1 and `vec_out` carries `cfg_vector`. `vec_oe` is 1 exactly when `dtack_n` is 0.
- R5: An acknowledge cycle with a different `addr_lvl`, with no outstanding request, or with `iack_n` high gets no response. `dtack_n` stays 1 and the request state is unchanged.
- R6: `dtack_n` stays 0 for as long as `ds_n` stays 0. It returns to 1, and `vec_oe` returns to 0, on the edge where `ds_n` is first sampled 1.
- R7: With `cfg_rora` = 0, the request is cleared on the same edge that releases `dtack_n`. The request line goes high together with `dtack_n`.
- R8: With `cfg_rora` = 1, the request line stays low after the acknowledge completes. It goes high only after a `local_clr` pulse.
- R9: A second `local_req` while a request is outstanding merges into it. One completed acknowledge (with `cfg_rora` = 0) releases the line.
- R10: After it responds, the block does not respond again until `as_n` has been sampled high, even if `ds_n` pulses low again.
- R11: When `local_req` and `local_clr` are sampled in the same cycle, the request wins and the line is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_level | input | 3 | Programmed priority level (0 = off) |
| cfg_vector | input | 8 | Identification vector returned on acknowledge |
| cfg_rora | input | 1 | 1 = keep request until local clear; 0 = drop on acknowledge |
| local_req | input | 1 | Request pulse from local logic |
| local_clr | input | 1 | Register-access clear pulse from local logic |
| iack_n | input | 1 | Bus interrupt acknowledge, active low |
| as_n | input | 1 | Bus address strobe, active low |
| ds_n | input | 1 | Bus data strobe, active low |
| addr_lvl | input | 3 | Level code taken from address bits 3..1 |
| irq_n | output | 7 | Request lines, bit k is level k+1, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| vec_out | output | 8 | Vector on the data lines |
| vec_oe | output | 1 | Output enable for the data lines |

## Verification
The hardest state to reach is a second data strobe that arrives after a completed response while the address strobe is still low. It matters only when the request survives the acknowledge, so the stimulus selects the keep-until-clear policy, completes one acknowledge and then pulses `ds_n` again without releasing `as_n`. Random rounds also mix level changes, including changes to 0 while a request is pending, with acknowledges at matching and non-matching levels. They also fire request and clear together, so the merge and precedence rules are exercised against a bench model.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
    localparam int LEVELS = 7;
    localparam int LVL_W  = $clog2(LEVELS + 1);
    localparam int VEC_W  = 8;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_DRIVE = 2'd1,
        ACK_HOLD  = 2'd2
    } ack_st_e;
endpackage

// File: rtl/irq_pending_ctl.sv
module irq_pending_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_req,
    input  logic clr_req,
    input  logic ack_done,
    input  logic keep_on_ack,
    output logic pending
);
    typedef struct packed {
        logic pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.pend = 1'b0;
        end else if (set_req) begin
            st_d.pend = 1'b1;
        end else if (clr_req || (ack_done && !keep_on_ack)) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;
endmodule

// File: rtl/irq_ack_resp.sv
module irq_ack_resp
    import irq_vector_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iack_n,
    input  logic          as_n,
    input  logic          ds_n,
    input  logic [LW-1:0] addr_lvl,
    input  logic [LW-1:0] level,
    input  logic          pending,
    input  logic [VW-1:0] vector,
    output logic          dtack_n,
    output logic          oe,
    output logic [VW-1:0] data,
    output logic          done
);
    typedef struct packed {
        ack_st_e       st;
        logic          dtack_n;
        logic          oe;
        logic [VW-1:0] data;
    } ack_state_t;

    ack_state_t s_d, s_q;
    logic       hit;

    assign hit = !iack_n && !as_n && !ds_n && pending &&
                 (level != '0) && (addr_lvl == level);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ACK_IDLE: begin
                if (hit) begin
                    s_d.st      = ACK_DRIVE;
                    s_d.dtack_n = 1'b0;
                    s_d.oe      = 1'b1;
                    s_d.data    = vector;
                end
            end
            ACK_DRIVE: begin
                if (ds_n) begin
                    s_d.st      = as_n ? ACK_IDLE : ACK_HOLD;
                    s_d.dtack_n = 1'b1;
                    s_d.oe      = 1'b0;
                    s_d.data    = '0;
                end
            end
            ACK_HOLD: begin
                if (as_n) s_d.st = ACK_IDLE;
            end
            default: s_d.st = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st      <= ACK_IDLE;
            s_q.dtack_n <= 1'b1;
            s_q.oe      <= 1'b0;
            s_q.data    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dtack_n = s_q.dtack_n;
    assign oe      = s_q.oe;
    assign data    = s_q.data;
    assign done    = (s_q.st == ACK_DRIVE) && ds_n;
endmodule

// File: rtl/irq_line_enc.sv
module irq_line_enc
    import irq_vector_pkg::*;
#(
    parameter int NL = LEVELS,
    parameter int LW = LVL_W
) (
    input  logic          pending,
    input  logic [LW-1:0] level,
    output logic [NL-1:0] irq_n
);
    for (genvar k = 0; k < NL; k++) begin : g_line
        assign irq_n[k] = !(pending && (level == LW'(k + 1)));
    end
endmodule

// File: rtl/irq_vector_src.sv
module irq_vector_src
    import irq_vector_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] cfg_level,
    input  logic [VEC_W-1:0] cfg_vector,
    input  logic             cfg_rora,
    input  logic             local_req,
    input  logic             local_clr,
    input  logic             iack_n,
    input  logic             as_n,
    input  logic             ds_n,
    input  logic [LVL_W-1:0] addr_lvl,
    output logic [LEVELS-1:0] irq_n,
    output logic             dtack_n,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_oe
);
    logic pending;
    logic ack_done;

    irq_pending_ctl u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_level != '0),
        .set_req     (local_req),
        .clr_req     (local_clr),
        .ack_done    (ack_done),
        .keep_on_ack (cfg_rora),
        .pending     (pending)
    );

    irq_ack_resp #(.LW(LVL_W), .VW(VEC_W)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .iack_n   (iack_n),
        .as_n     (as_n),
        .ds_n     (ds_n),
        .addr_lvl (addr_lvl),
        .level    (cfg_level),
        .pending  (pending),
        .vector   (cfg_vector),
        .dtack_n  (dtack_n),
        .oe       (vec_oe),
        .data     (vec_out),
        .done     (ack_done)
    );

    irq_line_enc #(.NL(LEVELS), .LW(LVL_W)) u_enc (
        .pending (pending),
        .level   (cfg_level),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk
    import irq_vector_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  cfg_level,
    input logic              cfg_rora,
    input logic              local_req,
    input logic              iack_n,
    input logic              as_n,
    input logic              ds_n,
    input logic [LEVELS-1:0] irq_n,
    input logic              dtack_n,
    input logic              vec_oe
);
    p_single_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n));

    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level == '0) |-> (&irq_n));

    p_oe_pairs_dtack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe == !dtack_n);

    p_dtack_needs_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(!iack_n && !as_n && !ds_n));

    p_release_after_ds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_n) |=> dtack_n);

    p_hold_while_ds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !ds_n) |=> !dtack_n);

    p_drop_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dtack_n) && !$past(cfg_rora) && !$past(local_req)) |-> (&irq_n));
endmodule

bind irq_vector_src irq_vector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_level (cfg_level),
    .cfg_rora  (cfg_rora),
    .local_req (local_req),
    .iack_n    (iack_n),
    .as_n      (as_n),
    .ds_n      (ds_n),
    .irq_n     (irq_n),
    .dtack_n   (dtack_n),
    .vec_oe    (vec_oe)
);

// File: tb/sim_irq_vector_src.sv
`timescale 1ns/1ps
module sim_irq_vector_src;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_level = '0;
    logic [7:0] cfg_vector = '0;
    logic       cfg_rora = 1'b0;
    logic       local_req = 1'b0;
    logic       local_clr = 1'b0;
    logic       iack_n = 1'b1;
    logic       as_n = 1'b1;
    logic       ds_n = 1'b1;
    logic [2:0] addr_lvl = '0;
    logic [6:0] irq_n;
    logic       dtack_n;
    logic [7:0] vec_out;
    logic       vec_oe;

    int checks = 0;
    int fails  = 0;
    bit model_pend = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_src u0 (.*);

    function automatic logic [6:0] exp_lines(bit pend, logic [2:0] lvl);
        logic [6:0] r = 7'h7f;
        if (pend && lvl != 0) r[lvl-1] = 1'b0;
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(bit req, bit clr);
        @(negedge clk);
        local_req = req; local_clr = clr;
        @(negedge clk);
        local_req = 0; local_clr = 0;
        if (cfg_level == 0) model_pend = 0;
        else if (req) model_pend = 1;
        else if (clr) model_pend = 0;
    endtask

    task automatic ack_cycle(logic [2:0] lvl, string req);
        bit resp;
        resp = model_pend && cfg_level != 0 && lvl == cfg_level;
        @(negedge clk);
        iack_n = 0; as_n = 0; ds_n = 0; addr_lvl = lvl;
        @(negedge clk);
        chk({req, " R4/R5 dtack"}, dtack_n, !resp);
        chk({req, " R4 oe"}, vec_oe, resp);
        chk({req, " R4 vector"}, vec_out, resp ? cfg_vector : 8'h00);
        @(negedge clk);
        chk({req, " R6 hold"}, dtack_n, !resp);
        ds_n = 1;
        @(negedge clk);
        if (resp && !cfg_rora) model_pend = 0;
        chk({req, " R6 release"}, {vec_oe, dtack_n}, 2'b01);
        chk({req, " R7/R8 lines after ack"}, irq_n, exp_lines(model_pend, cfg_level));
        as_n = 1; iack_n = 1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1f2e3d);
        repeat (3) @(negedge clk);
        chk("R1 lines", irq_n, 7'h7f);
        chk("R1 dtack", dtack_n, 1);
        chk("R1 oe/data", {vec_oe, vec_out}, 9'h0);
        rst_n = 1;
        @(negedge clk);

        // R2: level 5
        cfg_level = 3'd5; cfg_vector = 8'hA5; cfg_rora = 0;
        pulse(1, 0);
        chk("R2 line level 5", irq_n, 7'b1101111);
        // R5: wrong level, iack high
        ack_cycle(3'd4, "R5 wrong level");
        chk("R5 still pending", irq_n, 7'b1101111);
        @(negedge clk);
        iack_n = 1; as_n = 0; ds_n = 0; addr_lvl = 3'd5;
        @(negedge clk);
        chk("R5 no iack", dtack_n, 1);
        as_n = 1; ds_n = 1;
        // R9: merge then single ack releases (R7)
        pulse(1, 0);
        ack_cycle(3'd5, "R7 R9 merged");
        chk("R9 line released", irq_n, 7'h7f);
        ack_cycle(3'd5, "R5 no pending");

        // R8 and R10: keep policy
        cfg_rora = 1; cfg_level = 3'd2; cfg_vector = 8'h3C;
        pulse(1, 0);
        @(negedge clk);
        iack_n = 0; as_n = 0; ds_n = 0; addr_lvl = 3'd2;
        @(negedge clk);
        chk("R4 vector level 2", vec_out, 8'h3C);
        ds_n = 1;
        @(negedge clk);
        chk("R8 line kept", irq_n, 7'b1111101);
        ds_n = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 no re-response", dtack_n, 1);
        ds_n = 1; as_n = 1; iack_n = 1;
        @(negedge clk);
        pulse(0, 1);
        chk("R8 clear", irq_n, 7'h7f);
        // R11
        pulse(1, 1);
        chk("R11 request wins", irq_n, 7'b1111101);
        // R3: level to 0 discards, request ignored
        @(negedge clk); cfg_level = 0;
        @(negedge clk); model_pend = 0;
        chk("R3 lines off", irq_n, 7'h7f);
        pulse(1, 0);
        cfg_level = 3'd2;
        @(negedge clk);
        chk("R3 request ignored", irq_n, 7'h7f);

        // random rounds
        for (int i = 0; i < 300; i++) begin
            logic [2:0] lv;
            lv = 3'($urandom_range(0, 7));
            @(negedge clk);
            cfg_level = lv; cfg_rora = 1'($urandom);
            cfg_vector = 8'($urandom);
            @(negedge clk);
            if (lv == 0) model_pend = 0;
            chk("R2/R3 rand lines", irq_n, exp_lines(model_pend, cfg_level));
            case ($urandom_range(0, 3))
                0: pulse(1, 0);
                1: pulse(0, 1);
                2: pulse(1, 1);
                default: ;
            endcase
            chk("R2/R11 rand after pulse", irq_n, exp_lines(model_pend, cfg_level));
            if ($urandom_range(0, 1) == 1) ack_cycle(lv, "R4 rand match");
            else ack_cycle(3'($urandom_range(0, 7)), "R5 rand any");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule